// File: doc/BRIEF.md
# Watchdog Timer with Prescaler

This block is a down-counting watchdog for a CPU subsystem. It runs on the CPU clock. A prescaler divides that clock, and each prescaler tick lowers a main counter by one. If firmware lets the counter run out, the block reports an underflow. A non-volatile option word chooses the underflow action: a one-clock interrupt pulse or a one-clock reset-request pulse. After either action the counter reloads and keeps running.

To keep the counter from running out, firmware writes 00h and then FFh to the refresh port. This reloads the main counter only. The prescaler keeps its phase, so the real timeout after a refresh can be up to one prescaler period shorter than the nominal value.

The option word is captured only while reset is held. It gives three settings: the timeout length, whether counting starts by itself after reset, and the underflow action. Three live inputs are not captured at reset:
- the prescaler ratio select
- a low-speed-clock flag
- a halt input for stop and wait modes

Top module: `wdt_core`

## Requirements
- R1: Once running, an underflow occurs every RELOAD × ratio clock cycles. The counter drops by one on each prescaler tick. The tick that would take it below 1 is the underflow, and on that tick the counter reloads. With auto-start, the first underflow occurs on clock edge RELOAD × ratio after reset is released.
- R2: The 2-bit length option selects the reload value. Code 0 selects RELOAD_0, 1 selects RELOAD_1, 2 selects RELOAD_2 and 3 selects RELOAD_3. The defaults are 03FFh, 0FFFh, 1FFFh and 3FFFh.
- R3: The prescaler ratio is DIV_LO (default 16) when `div_hi_sel_i` is 0 and DIV_HI (default 128) when it is 1. When `low_speed_i` is 1, the ratio is DIV_LS (default 2), whatever `div_hi_sel_i` says.
- R4: The option inputs `opt_hold_i`, `opt_rst_act_i` and `opt_len_i` are captured only while `rst_n` is low. Changing them after reset has no effect.
- R5: With `opt_hold_i` = 0, counting starts on the first clock edge after reset and `running_o` is 1. With `opt_hold_i` = 1, `running_o` is 0 and no pulse occurs until a `start_wr_i` strobe. Counting then begins on the edge after the strobe is captured. A strobe while already running changes nothing.
- R6: A refresh reloads the counter when a write of 00h is followed by a write of FFh. A write of any other value in between disarms the sequence. A lone FFh write does not reload the counter.
- R7: A refresh does not clear the prescaler. After a reload on edge w with ratio r, the underflow falls on edge (floor(w/r) + RELOAD) × r. A tick on the same edge as the reload is absorbed by the reload.
- R8: Refresh writes made while the block is stopped are ignored. In particular, they do not arm the sequence.
- R9: While `halt_i` is 1, the prescaler and the counter hold their values. Counting resumes from the held values when `halt_i` returns to 0, so the underflow is delayed by exactly the number of halted cycles.
- R10: The underflow action depends on the captured `opt_rst_act_i`. A value of 0 gives a pulse on `irq_o` and a value of 1 gives a pulse on `rst_req_o`. The pulse lasts one cycle and is visible after the underflow edge. The two outputs are never high together.
- R11: During and right after reset, `irq_o` and `rst_req_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock (count source) |
| rst_n | input | 1 | Active-low synchronous system reset |
| opt_hold_i | input | 1 | Option bit: 1 = stay stopped after reset |
| opt_rst_act_i | input | 1 | Option bit: 1 = reset request on underflow, 0 = interrupt |
| opt_len_i | input | 2 | Option field selecting the reload value |
| div_hi_sel_i | input | 1 | Prescaler select: 0 = DIV_LO, 1 = DIV_HI |
| low_speed_i | input | 1 | Low-speed clock in use; forces ratio DIV_LS |
| halt_i | input | 1 | Stop or wait mode active; freezes counting |
| start_wr_i | input | 1 | Start register write strobe |
| refresh_wr_i | input | 1 | Refresh register write strobe |
| refresh_data_i | input | 8 | Data of the refresh register write |
| irq_o | output | 1 | Watchdog interrupt pulse |
| rst_req_o | output | 1 | Reset request pulse |
| running_o | output | 1 | Watchdog is counting |

## Verification
The assertions check these properties on every cycle:
- the two action pulses never overlap, last one cycle each, and only the selected action fires
- the counter always stays between 1 and its reload value
- once counting starts, it never stops
- while halted or stopped, the prescaler and the refresh arming hold still

Only the bench scenarios can show the actual timing. This covers:
- the exact underflow edge for every length and ratio combination
- the delay caused by a halt
- where a refresh lands relative to the prescaler phase
- that refresh writes made while stopped, wrong write orders and late option changes leave the schedule unchanged

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Option word captured while reset is held
    typedef struct packed {
        logic       hold;     // 1: stay stopped until start strobe
        logic       rst_act;  // 1: reset request, 0: interrupt
        logic [1:0] len;      // reload value select
    } wdt_opt_t;

    localparam logic [7:0] ARM_BYTE  = 8'h00;
    localparam logic [7:0] FIRE_BYTE = 8'hFF;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int DIV_LO = 16,
    parameter int DIV_HI = 128,
    parameter int DIV_LS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic hi_sel_i,
    input  logic low_speed_i,
    output logic tick_o
);
    localparam int MAX_A = (DIV_LO > DIV_HI) ? DIV_LO : DIV_HI;
    localparam int MAX_D = (MAX_A > DIV_LS) ? MAX_A : DIV_LS;
    localparam int PRE_W = (MAX_D > 2) ? $clog2(MAX_D) : 1;
    localparam logic [PRE_W-1:0] LO_M1 = PRE_W'(DIV_LO - 1);
    localparam logic [PRE_W-1:0] HI_M1 = PRE_W'(DIV_HI - 1);
    localparam logic [PRE_W-1:0] LS_M1 = PRE_W'(DIV_LS - 1);

    typedef struct packed {
        logic [PRE_W-1:0] phase;
    } pre_state_t;

    pre_state_t pre_q, pre_d;
    logic [PRE_W-1:0] last_phase;

    always_comb begin
        pre_d      = pre_q;
        last_phase = low_speed_i ? LS_M1 : (hi_sel_i ? HI_M1 : LO_M1);
        tick_o     = en_i && (pre_q.phase >= last_phase);
        if (en_i) begin
            if (tick_o) pre_d.phase = '0;
            else        pre_d.phase = pre_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R9
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(pre_q.phase));

endmodule

// File: rtl/wdt_refresh_seq.sv
module wdt_refresh_seq
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       wr_i,
    input  logic [7:0] data_i,
    output logic       kick_o
);
    typedef struct packed {
        logic armed;
    } seq_state_t;

    seq_state_t seq_q, seq_d;

    always_comb begin
        seq_d  = seq_q;
        kick_o = 1'b0;
        if (en_i && wr_i) begin
            if (data_i == ARM_BYTE) begin
                seq_d.armed = 1'b1;
            end else begin
                kick_o      = seq_q.armed && (data_i == FIRE_BYTE);
                seq_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    // R8
    stopped_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(seq_q.armed));

    // R6
    kick_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick_o |=> !seq_q.armed);

endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int          CNT_W    = 14,
    parameter int          DIV_LO   = 16,
    parameter int          DIV_HI   = 128,
    parameter int          DIV_LS   = 2,
    parameter logic [CNT_W-1:0] RELOAD_0 = CNT_W'(14'h03FF),
    parameter logic [CNT_W-1:0] RELOAD_1 = CNT_W'(14'h0FFF),
    parameter logic [CNT_W-1:0] RELOAD_2 = CNT_W'(14'h1FFF),
    parameter logic [CNT_W-1:0] RELOAD_3 = CNT_W'(14'h3FFF)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       opt_hold_i,
    input  logic       opt_rst_act_i,
    input  logic [1:0] opt_len_i,
    input  logic       div_hi_sel_i,
    input  logic       low_speed_i,
    input  logic       halt_i,
    input  logic       start_wr_i,
    input  logic       refresh_wr_i,
    input  logic [7:0] refresh_data_i,
    output logic       irq_o,
    output logic       rst_req_o,
    output logic       running_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        wdt_opt_t         opt;
        logic             running;
        logic [CNT_W-1:0] cnt;
        logic             irq;
        logic             rst_req;
    } core_state_t;

    core_state_t q, d;
    logic tick, kick, count_en;
    logic [CNT_W-1:0] reload_val, reset_reload;

    function automatic logic [CNT_W-1:0] pick_reload(input logic [1:0] code);
        case (code)
            2'd0:    pick_reload = RELOAD_0;
            2'd1:    pick_reload = RELOAD_1;
            2'd2:    pick_reload = RELOAD_2;
            default: pick_reload = RELOAD_3;
        endcase
    endfunction

    assign count_en     = q.running && !halt_i;
    assign reload_val   = pick_reload(q.opt.len);
    assign reset_reload = pick_reload(opt_len_i);

    wdt_prescaler #(
        .DIV_LO(DIV_LO),
        .DIV_HI(DIV_HI),
        .DIV_LS(DIV_LS)
    ) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (count_en),
        .hi_sel_i   (div_hi_sel_i),
        .low_speed_i(low_speed_i),
        .tick_o     (tick)
    );

    wdt_refresh_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (q.running),
        .wr_i  (refresh_wr_i),
        .data_i(refresh_data_i),
        .kick_o(kick)
    );

    always_comb begin
        d         = q;
        d.irq     = 1'b0;
        d.rst_req = 1'b0;
        if (start_wr_i) d.running = 1'b1;
        if (kick) begin
            d.cnt = reload_val;
        end else if (tick) begin
            if (q.cnt <= ONE) begin
                d.cnt = reload_val;
                if (q.opt.rst_act) d.rst_req = 1'b1;
                else               d.irq     = 1'b1;
            end else begin
                d.cnt = q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.opt     <= '{hold: opt_hold_i, rst_act: opt_rst_act_i, len: opt_len_i};
            q.running <= !opt_hold_i;
            q.cnt     <= reset_reload;
            q.irq     <= 1'b0;
            q.rst_req <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign irq_o     = q.irq;
    assign rst_req_o = q.rst_req;
    assign running_o = q.running;

    // R10
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_o && rst_req_o));

    // R10
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R10
    rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);

    // R10
    action_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o |-> !q.opt.rst_act) and (rst_req_o |-> q.opt.rst_act));

    // R5
    running_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running_o |=> running_o);

    // R5
    stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running_o |=> !irq_o && !rst_req_o);

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt >= ONE) && (q.cnt <= reload_val));

    // R4
    opt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(q.opt));

endmodule

// File: tb/wdt_core_tb.sv
module wdt_core_tb;
    localparam int DLO = 4;
    localparam int DHI = 8;
    localparam int DLS = 2;
    localparam int RL [4] = '{2, 3, 5, 7};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       opt_hold = 1'b0, opt_rst_act = 1'b0;
    logic [1:0] opt_len = 2'd0;
    logic       div_hi = 1'b0, low_speed = 1'b0, halt = 1'b0, start_wr = 1'b0;
    logic       ref_wr = 1'b0;
    logic [7:0] ref_data = 8'h00;
    logic       irq_o, rst_req_o, running_o;

    int tests = 0;
    int fails = 0;
    int edges = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    always @(posedge clk) edges <= rst_n ? edges + 1 : 0;

    wdt_core #(
        .CNT_W(4), .DIV_LO(DLO), .DIV_HI(DHI), .DIV_LS(DLS),
        .RELOAD_0(4'd2), .RELOAD_1(4'd3), .RELOAD_2(4'd5), .RELOAD_3(4'd7)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .opt_hold_i(opt_hold), .opt_rst_act_i(opt_rst_act),
        .opt_len_i(opt_len), .div_hi_sel_i(div_hi), .low_speed_i(low_speed),
        .halt_i(halt), .start_wr_i(start_wr), .refresh_wr_i(ref_wr),
        .refresh_data_i(ref_data), .irq_o(irq_o), .rst_req_o(rst_req_o),
        .running_o(running_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input bit hold, input bit act, input int len);
        @(negedge clk);
        rst_n = 1'b0; opt_hold = hold; opt_rst_act = act; opt_len = 2'(len);
        halt = 1'b0; start_wr = 1'b0; ref_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_edge(input int target);
        while (edges < target) @(negedge clk);
    endtask

    task automatic wr_ref(input logic [7:0] v);
        ref_wr = 1'b1; ref_data = v;
        @(negedge clk);
        ref_wr = 1'b0;
    endtask

    // Returns the edge after which a pulse is seen, or -1
    task automatic next_pulse(input int lim, output int at, output bit was_irq, output bit was_rst);
        at = -1; was_irq = 1'b0; was_rst = 1'b0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (irq_o || rst_req_o) begin
                at = edges; was_irq = irq_o; was_rst = rst_req_o;
                break;
            end
        end
    endtask

    initial begin
        int at, r, exp;
        bit wi, wr;

        // R11: reset state
        do_reset(1'b0, 1'b0, 0);
        chk(irq_o == 1'b0 && rst_req_o == 1'b0, "R11 pulses low after reset", irq_o | rst_req_o, 0);
        chk(running_o == 1'b1, "R5 running after auto-start reset", running_o, 1);

        // R1 R2 R3 R4 R10: sweep length, ratio mode and action
        for (int len = 0; len < 4; len++) begin
            for (int mode = 0; mode < 3; mode++) begin
                bit act;
                act = 1'(len + mode);
                div_hi    = (mode != 0);
                low_speed = (mode == 2);
                r = (mode == 0) ? DLO : (mode == 1) ? DHI : DLS;
                do_reset(1'b0, act, len);
                // R4: later option changes must not matter
                opt_len = ~opt_len; opt_rst_act = ~act; opt_hold = 1'b1;
                exp = RL[len] * r;
                next_pulse(3 * exp, at, wi, wr);
                chk(at == exp, "R1 R2 R3 R4 first underflow edge", at, exp);
                chk(wi == !act && wr == act, "R10 action select", {wi, wr}, act ? 1 : 2);
                next_pulse(3 * exp, at, wi, wr);
                chk(at == 2 * exp, "R1 period between underflows", at, 2 * exp);
                chk(wi == !act && wr == act, "R10 action repeat", {wi, wr}, act ? 1 : 2);
            end
        end
        div_hi = 1'b0; low_speed = 1'b0;

        // R6 R7: valid refresh at edge 7, ratio 4, reload 3
        do_reset(1'b0, 1'b0, 1);
        wait_edge(5);
        wr_ref(8'h00); wr_ref(8'hFF);
        next_pulse(100, at, wi, wr);
        exp = ((7 / DLO) + RL[1]) * DLO;
        chk(at == exp, "R6 R7 refresh reloads, prescaler kept", at, exp);

        // R6: broken sequence does not reload
        do_reset(1'b0, 1'b0, 1);
        wait_edge(5);
        wr_ref(8'h00); wr_ref(8'h5A); wr_ref(8'hFF);
        next_pulse(100, at, wi, wr);
        chk(at == RL[1] * DLO, "R6 intervening write disarms", at, RL[1] * DLO);

        // R6: lone FF does not reload
        do_reset(1'b0, 1'b0, 1);
        wait_edge(5);
        wr_ref(8'hFF);
        next_pulse(100, at, wi, wr);
        chk(at == RL[1] * DLO, "R6 lone FF ignored", at, RL[1] * DLO);

        // R7: refresh on a tick edge (edge 8) absorbs the tick
        do_reset(1'b0, 1'b0, 1);
        wait_edge(6);
        wr_ref(8'h00); wr_ref(8'hFF);
        next_pulse(100, at, wi, wr);
        exp = ((8 / DLO) + RL[1]) * DLO;
        chk(at == exp, "R7 refresh on tick edge", at, exp);

        // R5: start strobe while running has no effect
        do_reset(1'b0, 1'b1, 2);
        wait_edge(5);
        start_wr = 1'b1; @(negedge clk); start_wr = 1'b0;
        next_pulse(100, at, wi, wr);
        chk(at == RL[2] * DLO && wr, "R5 start while running ignored", at, RL[2] * DLO);

        // R5 R8: held after reset, writes ignored while stopped
        do_reset(1'b1, 1'b0, 1);
        next_pulse(40, at, wi, wr);
        chk(at == -1, "R5 no pulse while stopped", at, -1);
        chk(running_o == 1'b0, "R5 running low while stopped", running_o, 0);
        wait_edge(40);
        wr_ref(8'h00);                         // captured on edge 41, ignored
        start_wr = 1'b1; @(negedge clk); start_wr = 1'b0;   // captured on edge 42
        chk(running_o == 1'b1, "R5 start strobe begins counting", running_o, 1);
        wait_edge(46);
        wr_ref(8'hFF);                         // edge 47: must not complete a refresh
        next_pulse(100, at, wi, wr);
        exp = 42 + RL[1] * DLO;
        chk(at == exp, "R8 stopped-time arm ignored; R5 start timing", at, exp);

        // R9: halt delays by exactly the halted cycles
        do_reset(1'b0, 1'b0, 3);
        wait_edge(6);
        halt = 1'b1;
        repeat (9) @(negedge clk);
        halt = 1'b0;
        next_pulse(200, at, wi, wr);
        exp = RL[3] * DLO + 9;
        chk(at == exp, "R9 halt freezes count", at, exp);

        // R9: halt across a tick edge with the high ratio
        div_hi = 1'b1;
        do_reset(1'b0, 1'b1, 0);
        wait_edge(7);
        halt = 1'b1;
        repeat (5) @(negedge clk);
        halt = 1'b0;
        next_pulse(200, at, wi, wr);
        exp = RL[0] * DHI + 5;
        chk(at == exp && wr, "R9 halt across tick edge", at, exp);
        div_hi = 1'b0;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule